// File: doc/BRIEF.md
# Charge Safety Timer

This block bounds the length of a battery charge cycle. A periodic time-base tick advances an internal count. The count is compared against one of two budgets, and the battery phase picks which one: a short budget while the cell is below its low-voltage threshold, and a long budget above it. The count advances at half rate while charging is derated, which means input-current regulation, die thermal regulation, or the cool or warm battery temperature zone. The count holds its value while any protection fault is present and picks up again from the held value once all faults clear.

A defined set of events clears the count. Each event is detected inside the block from a level input:

- the battery falling below the recharge threshold;
- the input supply returning;
- any change on the enable input;
- any crossing of the short threshold or the low-voltage threshold.

When the budget runs out, the block raises an expired flag and a charge-suspend request. Both stay high until the next clear. Expiry is classed as a fault only if the battery is below the recharge threshold at that moment. The fault flag is sticky and only a timer clear removes it.

Budgets are given in ticks as parameters. Real hours come from the tick period, so simulation can use short budgets.

Top module: `charge_safety_timer`

## Requirements
- R1: With `lowBatt` = 0, `expired` stays 0 after FAST_TICKS-1 counted ticks and is 1 within two clock cycles after the FAST_TICKS-th tick.
- R2: With `lowBatt` = 1, the budget is PRE_TICKS ticks, with the same timing as R1.
- R3: While any of `inCurReg`, `thermReg`, `zoneCool` or `zoneWarm` is 1, only every second tick is counted. The budget therefore takes twice as many ticks: 2*FAST_TICKS-1 ticks do not expire it and 2*FAST_TICKS ticks do.
- R4: While any of `tsFault`, `vinOvp`, `vbatOvp`, `isetFault` or `dieShutdown` is 1, ticks are ignored. Counting resumes from the held value when all of them are 0.
- R5: Each of the following clears the count, `expired` and `expFault`:
  - a 0-to-1 change of `belowRecharge`;
  - a 0-to-1 change of `vinPresent`;
  - any change of `enable`;
  - any change of `belowShort`;
  - any change of `lowBatt`.

  A 1-to-0 change of `vinPresent` is not a clear.
- R6: If a clear event and a tick occur in the same cycle, the clear wins and that tick is not counted.
- R7: `suspendReq` is 1 from expiry until the next clear event, and 0 otherwise.
- R8: On expiry, `expFault` becomes 1 if `belowRecharge` is 1 in that cycle. If `belowRecharge` is 0, `expFault` stays 0 while `expired` is 1.
- R9: Once set, `expFault` stays 1 until a clear event, even if `belowRecharge` later returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base pulse, one cycle wide |
| lowBatt | input | 1 | 1 = battery below low-voltage threshold (precharge phase) |
| belowShort | input | 1 | 1 = battery below short threshold |
| belowRecharge | input | 1 | 1 = battery below recharge threshold |
| vinPresent | input | 1 | 1 = input supply valid |
| enable | input | 1 | Charger enable level |
| inCurReg | input | 1 | Input-current regulation active |
| thermReg | input | 1 | Die thermal regulation active |
| zoneCool | input | 1 | Battery in cool temperature zone |
| zoneWarm | input | 1 | Battery in warm temperature zone |
| tsFault | input | 1 | Thermistor out-of-range fault |
| vinOvp | input | 1 | Input over-voltage |
| vbatOvp | input | 1 | Battery over-voltage |
| isetFault | input | 1 | Current-setting pin open or short |
| dieShutdown | input | 1 | Die thermal shutdown |
| expired | output | 1 | Budget exhausted |
| expFault | output | 1 | Expiry classed as fault (status should blink) |
| suspendReq | output | 1 | Request to suspend charging |

## Verification
The budget is run out in four settings, each told apart by the tick count at which expiry first appears:

- plain fast phase, which expires at the long budget;
- precharge phase, which expires at the short budget;
- a derated phase, which takes twice as many ticks;
- a run with a fault in the middle, where the ticks during the fault must not count.

Each clear source is toggled after an expiry, to show that it alone removes the flags. A falling supply is shown not to clear. A clear placed in the same cycle as a tick shows that the clear takes priority. The fault classification is tried with the battery above and below the recharge threshold. The fault is then checked to stay set after the battery voltage recovers.

// File: rtl/cst_pkg.sv
package cst_pkg;
  typedef struct packed {
    logic clr;   // restart count and half-rate phase
    logic adv;   // a tick is to be applied
    logic slow;  // apply it at half rate
  } cstStrobe_t;
endpackage

// File: rtl/cst_datapath.sv
module cst_datapath #(
  parameter int PRE_TICKS  = 6,
  parameter int FAST_TICKS = 10,
  localparam int MaxTicks  = (PRE_TICKS > FAST_TICKS) ? PRE_TICKS : FAST_TICKS,
  localparam int CntW      = $clog2(MaxTicks + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  cst_pkg::cstStrobe_t stb,
  input  logic                lowBatt,
  output logic                atLimit
);
  logic [CntW-1:0] count;
  logic            halfPhase;
  logic [CntW-1:0] limit;

  assign limit   = lowBatt ? CntW'(PRE_TICKS) : CntW'(FAST_TICKS);
  assign atLimit = (count >= limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      halfPhase <= 1'b0;
    end else if (stb.clr) begin
      count     <= '0;
      halfPhase <= 1'b0;
    end else if (stb.adv) begin
      if (stb.slow) begin
        halfPhase <= ~halfPhase;
        if (halfPhase) count <= count + 1'b1;
      end else begin
        count <= count + 1'b1;
      end
    end
  end

  // R1/R2: the count never runs past the larger budget
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= CntW'(MaxTicks));

  // R4: without an advance or clear strobe the count holds
  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.adv && !stb.clr) |=> $stable(count));

  // R5: a clear strobe leaves the count below every budget
  a_r5_clear_restarts: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> !atLimit);
endmodule

// File: rtl/cst_control.sv
module cst_control (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic                lowBatt,
  input  logic                belowShort,
  input  logic                belowRecharge,
  input  logic                vinPresent,
  input  logic                enable,
  input  logic                derate,
  input  logic                pauseAny,
  input  logic                atLimit,
  output cst_pkg::cstStrobe_t stb,
  output logic                expired,
  output logic                expFault
);
  logic lowPrev, shortPrev, rechPrev, vinPrev, enPrev;
  logic clrEvt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowPrev   <= 1'b0;
      shortPrev <= 1'b0;
      rechPrev  <= 1'b0;
      vinPrev   <= 1'b0;
      enPrev    <= 1'b0;
    end else begin
      lowPrev   <= lowBatt;
      shortPrev <= belowShort;
      rechPrev  <= belowRecharge;
      vinPrev   <= vinPresent;
      enPrev    <= enable;
    end
  end

  // R5: clear sources, all detected from level inputs
  assign clrEvt = (belowRecharge & ~rechPrev) | (vinPresent & ~vinPrev) |
                  (enable ^ enPrev) | (belowShort ^ shortPrev) |
                  (lowBatt ^ lowPrev);

  // R6: a clear suppresses any tick in the same cycle
  always_comb begin
    stb.clr  = clrEvt;
    stb.adv  = tick & ~pauseAny & ~expired & ~atLimit & ~clrEvt;
    stb.slow = derate;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expired  <= 1'b0;
      expFault <= 1'b0;
    end else if (clrEvt) begin
      expired  <= 1'b0;
      expFault <= 1'b0;
    end else if (atLimit && !expired) begin
      expired  <= 1'b1;
      expFault <= belowRecharge;
    end
  end

  // R8: a fault is only ever reported together with expiry
  a_r8_fault_needs_expiry: assert property (@(posedge clk) disable iff (!rstN)
    expFault |-> expired);

  // R9: the fault persists until a clear event
  a_r9_fault_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (expFault && !clrEvt) |=> expFault);

  // R7: expiry persists until a clear event
  a_r7_expiry_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (expired && !clrEvt) |=> expired);

  // R5: a clear removes both flags on the next cycle
  a_r5_clear_flags: assert property (@(posedge clk) disable iff (!rstN)
    clrEvt |=> (!expired && !expFault));
endmodule

// File: rtl/charge_safety_timer.sv
module charge_safety_timer #(
  parameter int PRE_TICKS  = 6,
  parameter int FAST_TICKS = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic lowBatt,
  input  logic belowShort,
  input  logic belowRecharge,
  input  logic vinPresent,
  input  logic enable,
  input  logic inCurReg,
  input  logic thermReg,
  input  logic zoneCool,
  input  logic zoneWarm,
  input  logic tsFault,
  input  logic vinOvp,
  input  logic vbatOvp,
  input  logic isetFault,
  input  logic dieShutdown,
  output logic expired,
  output logic expFault,
  output logic suspendReq
);
  cst_pkg::cstStrobe_t stb;
  logic atLimit;
  logic derate;
  logic pauseAny;

  assign derate     = inCurReg | thermReg | zoneCool | zoneWarm;
  assign pauseAny   = tsFault | vinOvp | vbatOvp | isetFault | dieShutdown;
  assign suspendReq = expired;

  cst_control uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .lowBatt(lowBatt),
    .belowShort(belowShort), .belowRecharge(belowRecharge),
    .vinPresent(vinPresent), .enable(enable), .derate(derate),
    .pauseAny(pauseAny), .atLimit(atLimit), .stb(stb),
    .expired(expired), .expFault(expFault)
  );

  cst_datapath #(.PRE_TICKS(PRE_TICKS), .FAST_TICKS(FAST_TICKS)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .lowBatt(lowBatt), .atLimit(atLimit)
  );
endmodule

// File: tb/tb_charge_safety_timer.sv
module tb_charge_safety_timer;
  localparam int Pre  = 6;
  localparam int Fast = 10;

  logic clk = 0;
  logic rstN = 0;
  logic tick = 0, lowBatt = 0, belowShort = 0, belowRecharge = 0;
  logic vinPresent = 1, enable = 0;
  logic inCurReg = 0, thermReg = 0, zoneCool = 0, zoneWarm = 0;
  logic tsFault = 0, vinOvp = 0, vbatOvp = 0, isetFault = 0, dieShutdown = 0;
  logic expired, expFault, suspendReq;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  charge_safety_timer #(.PRE_TICKS(Pre), .FAST_TICKS(Fast)) dut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clearByEnable();
    @(negedge clk) enable = ~enable;
    settle();
  endtask

  task automatic t_reset();
    chk("R7 reset expired", expired, 1'b0);
    chk("R8 reset fault", expFault, 1'b0);
    chk("R7 reset suspend", suspendReq, 1'b0);
  endtask

  task automatic t_fast();
    clearByEnable();
    ticks(Fast - 1);
    chk("R1 before budget", expired, 1'b0);
    ticks(1);
    chk("R1 at budget", expired, 1'b1);
    chk("R7 suspend on expiry", suspendReq, 1'b1);
    chk("R8 no fault above recharge", expFault, 1'b0);
    clearByEnable();
    chk("R5 enable toggle clears", expired, 1'b0);
    chk("R7 suspend released", suspendReq, 1'b0);
  endtask

  task automatic t_pre_fault();
    @(negedge clk) belowRecharge = 1;
    @(negedge clk) lowBatt = 1;
    settle();
    ticks(Pre - 1);
    chk("R2 before budget", expired, 1'b0);
    ticks(1);
    chk("R2 at budget", expired, 1'b1);
    chk("R8 fault below recharge", expFault, 1'b1);
    @(negedge clk) belowRecharge = 0;
    settle();
    chk("R9 fault sticky after recovery", expFault, 1'b1);
    @(negedge clk) vinPresent = 0;
    settle();
    chk("R5 supply loss is not a clear", expFault, 1'b1);
    @(negedge clk) vinPresent = 1;
    settle();
    chk("R5 supply return clears fault", expFault, 1'b0);
    chk("R5 supply return clears expiry", expired, 1'b0);
    @(negedge clk) lowBatt = 0;
    settle();
  endtask

  task automatic t_half();
    @(negedge clk) zoneCool = 1;
    clearByEnable();
    ticks(2 * Fast - 1);
    chk("R3 half rate not yet", expired, 1'b0);
    ticks(1);
    chk("R3 half rate doubled budget", expired, 1'b1);
    @(negedge clk) zoneCool = 0;
    clearByEnable();
  endtask

  task automatic t_pause();
    ticks(5);
    @(negedge clk) tsFault = 1;
    ticks(Fast);
    chk("R4 paused ignores ticks", expired, 1'b0);
    @(negedge clk) tsFault = 0;
    ticks(Fast - 5 - 1);
    chk("R4 resumes from held value", expired, 1'b0);
    ticks(1);
    chk("R4 expires after remainder", expired, 1'b1);
    clearByEnable();
  endtask

  task automatic t_tie();
    ticks(Fast - 1);
    @(negedge clk) begin tick = 1; enable = ~enable; end
    @(negedge clk) tick = 0;
    settle();
    chk("R6 clear wins tie", expired, 1'b0);
    ticks(Fast - 1);
    chk("R6 tick in tie not counted", expired, 1'b0);
    ticks(1);
    chk("R6 full budget after tie", expired, 1'b1);
    @(negedge clk) belowShort = 1;
    settle();
    chk("R5 short crossing clears", expired, 1'b0);
    ticks(Fast);
    @(negedge clk) belowRecharge = 1;
    settle();
    chk("R5 recharge drop clears", expired, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    settle();
    t_reset();
    t_fast();
    t_pre_fault();
    t_half();
    t_pause();
    t_tie();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule